// File: doc/BRIEF.md
# Rotating Line-Buffer Tap Selector

A five-tap vertical filter reads five vertically adjacent image lines at once, and a sixth buffer is loaded with the following line while the current one is processed. This block steers the data without moving it between buffers. It keeps six 3-bit buffer codes in a small register. Five of the codes pick which buffer feeds each filter tap. The sixth code names the buffer that is free to be filled.

When the scan advances one line, a single shift strobe rotates the codes. Every line then moves one tap position toward the top of the window. The buffer that held the oldest line becomes the free buffer, and the buffer that was just filled becomes the newest tap. The buffer storage sits outside the block. The block only receives the current output word of each buffer and routes it to the taps through combinational logic.

Top module: `lbsel_top`

## Requirements
- R1: While `rst_n` is low, and from then until the first shift or init, tap j (j = 0 for line n-2 up to j = 4 for line n+2) selects buffer code j and `free_code` is 5.
- R2: Tap j's 8-bit output, at `tap_data[8j+7:8j]`, equals `buf_data[8b+7:8b]`, where b is the code currently held for tap j. A change on `buf_data` appears on the taps in the same cycle, with no register in the path.
- R3: On a clock edge with `shift` high and `init` low, tap j for j = 0..3 takes the code that tap j+1 held, and tap 4 takes the previous `free_code`.
- R4: On a clock edge with `shift` high and `init` low, the code that tap 0 held becomes the new `free_code`.
- R5: On a clock edge with both `shift` and `init` low, every code, and so every routing and `free_code`, stays unchanged.
- R6: A clock edge with `init` high restores the R1 arrangement, whether `shift` is high or low.
- R7: Six consecutive shifts pass through six distinct arrangements and return to the R1 arrangement.
- R8: The six codes always form a permutation of 0..5, so the five taps read five different buffers and none of them is the free buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init | input | 1 | Synchronous return to the start arrangement |
| shift | input | 1 | Advance the window by one line |
| buf_data | input | 48 | Current word of buffers 0..5; buffer b is at bits 8b+7:8b |
| tap_data | output | 40 | Filter tap words; tap j (n-2+j) is at bits 8j+7:8j |
| free_code | output | 3 | Code of the buffer free for loading |

## Verification
The bench uses the default build of six buffers with 8-bit data. With that build a run of shifts covers all six rotation states and the wrap back to the start, and the free code reaches every value 0..5. Each buffer carries a distinct, changing word, so a tap that reads the wrong buffer shows up directly at the tap outputs. The bench also drives init together with shift, asserts reset in the middle of a rotation, and changes buffer data between edges to show that the routing is combinational.

// File: rtl/lbsel_pkg.sv
package lbsel_pkg;

  // Command applied to the code register on a clock edge
  typedef enum logic [1:0] {
    CMD_HOLD  = 2'd0,
    CMD_SHIFT = 2'd1,
    CMD_INIT  = 2'd2
  } lbsel_cmd_e;

endpackage

// File: rtl/lbsel_ring_reg.sv
module lbsel_ring_reg
  import lbsel_pkg::*;
#(
  parameter int NUM_BUF = 6,
  parameter int CODE_W  = $clog2(NUM_BUF)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  lbsel_cmd_e                       cmd,
  output logic [NUM_BUF-1:0][CODE_W-1:0]   fields_q
);

  logic [NUM_BUF-1:0][CODE_W-1:0] fields_d;
  logic [NUM_BUF-1:0][CODE_W-1:0] start_pat;
  logic                           load_en;

  // Start arrangement: field i holds code i (last field = free buffer)
  always_comb begin
    for (int i = 0; i < NUM_BUF; i++) begin
      start_pat[i] = CODE_W'(i);
    end
  end

  assign load_en = (cmd != CMD_HOLD);

  // Next-state: rotate toward field 0, field 0 wraps into the free field
  always_comb begin
    fields_d = fields_q;
    unique case (cmd)
      CMD_INIT:  fields_d = start_pat;
      CMD_SHIFT: begin
        for (int i = 0; i < NUM_BUF; i++) begin
          fields_d[i] = fields_q[(i + 1) % NUM_BUF];
        end
      end
      default:   fields_d = fields_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fields_q <= start_pat;
    end else if (load_en) begin
      fields_q <= fields_d;
    end
  end

endmodule

// File: rtl/lbsel_tap_mux.sv
module lbsel_tap_mux #(
  parameter int NUM_BUF = 6,
  parameter int DATA_W  = 8,
  parameter int CODE_W  = $clog2(NUM_BUF)
) (
  input  logic [CODE_W-1:0]         sel,
  input  logic [NUM_BUF*DATA_W-1:0] buf_data,
  output logic [DATA_W-1:0]         tap_out
);

  // One-of-NUM_BUF select; unused code values yield zero
  always_comb begin
    tap_out = '0;
    for (int b = 0; b < NUM_BUF; b++) begin
      if (sel == CODE_W'(b)) begin
        tap_out = buf_data[b*DATA_W +: DATA_W];
      end
    end
  end

endmodule

// File: rtl/lbsel_top.sv
module lbsel_top
  import lbsel_pkg::*;
#(
  parameter int NUM_BUF = 6,
  parameter int DATA_W  = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              init,
  input  logic                              shift,
  input  logic [NUM_BUF*DATA_W-1:0]         buf_data,
  output logic [(NUM_BUF-1)*DATA_W-1:0]     tap_data,
  output logic [$clog2(NUM_BUF)-1:0]        free_code
);

  localparam int CODE_W   = $clog2(NUM_BUF);
  localparam int NUM_TAPS = NUM_BUF - 1;

  lbsel_cmd_e                     cmd;
  logic [NUM_BUF-1:0][CODE_W-1:0] fields_q;

  // init has priority over shift
  always_comb begin
    if (init)       cmd = CMD_INIT;
    else if (shift) cmd = CMD_SHIFT;
    else            cmd = CMD_HOLD;
  end

  lbsel_ring_reg #(
    .NUM_BUF (NUM_BUF),
    .CODE_W  (CODE_W)
  ) u_ring (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd),
    .fields_q (fields_q)
  );

  for (genvar j = 0; j < NUM_TAPS; j++) begin : g_tap
    lbsel_tap_mux #(
      .NUM_BUF (NUM_BUF),
      .DATA_W  (DATA_W),
      .CODE_W  (CODE_W)
    ) u_mux (
      .sel      (fields_q[j]),
      .buf_data (buf_data),
      .tap_out  (tap_data[j*DATA_W +: DATA_W])
    );
  end

  assign free_code = fields_q[NUM_BUF-1];

endmodule

// File: rtl/lbsel_chk.sv
module lbsel_chk #(
  parameter int NUM_BUF = 6,
  parameter int DATA_W  = 8,
  parameter int CODE_W  = $clog2(NUM_BUF)
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              init,
  input logic                              shift,
  input logic [NUM_BUF*DATA_W-1:0]         buf_data,
  input logic [(NUM_BUF-1)*DATA_W-1:0]     tap_data,
  input logic [CODE_W-1:0]                 free_code,
  input logic [NUM_BUF-1:0][CODE_W-1:0]    fields
);

  localparam int NUM_TAPS = NUM_BUF - 1;

  logic [NUM_BUF-1:0] seen;
  always_comb begin
    seen = '0;
    for (int i = 0; i < NUM_BUF; i++) begin
      if (int'(fields[i]) < NUM_BUF) seen[fields[i]] = 1'b1;
    end
  end

  // R8: all six codes present, no duplicate
  a_r8_permutation: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(seen) == NUM_BUF);

  // R4: released tap-0 code becomes free
  a_r4_free_takes_oldest: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !init) |=> free_code == $past(fields[0]));

  // R3: previous free code becomes newest tap
  a_r3_free_to_newest: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !init) |=> fields[NUM_TAPS-1] == $past(free_code));

  // R5: idle edge keeps the arrangement
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift && !init) |=> $stable(fields));

  // R6: init restores start arrangement
  a_r6_init_start: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (free_code == CODE_W'(NUM_BUF-1)) && (fields[0] == '0));

  for (genvar j = 0; j < NUM_TAPS; j++) begin : g_route
    // R2: tap word comes from the buffer its code names
    a_r2_route: assert property (@(posedge clk) disable iff (!rst_n)
      tap_data[j*DATA_W +: DATA_W] == buf_data[int'(fields[j])*DATA_W +: DATA_W]);
  end

endmodule

bind lbsel_top lbsel_chk #(
  .NUM_BUF (NUM_BUF),
  .DATA_W  (DATA_W)
) u_lbsel_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .init      (init),
  .shift     (shift),
  .buf_data  (buf_data),
  .tap_data  (tap_data),
  .free_code (free_code),
  .fields    (fields_q)
);

// File: tb/test_lbsel_top.sv
module test_lbsel_top;

  localparam int CLK_PERIOD = 10;
  localparam int NB   = 6;
  localparam int DW   = 8;
  localparam int NT   = NB - 1;
  localparam int CW   = $clog2(NB);

  logic              clk;
  logic              rst_n;
  logic              init;
  logic              shift;
  logic [NB*DW-1:0]  buf_data;
  logic [NT*DW-1:0]  tap_data;
  logic [CW-1:0]     free_code;

  int n_checks;
  int n_fail;
  int rot;        // reference rotation count, 0..5
  bit done;

  lbsel_top #(.NUM_BUF(NB), .DATA_W(DW)) i_lbsel_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .init      (init),
    .shift     (shift),
    .buf_data  (buf_data),
    .tap_data  (tap_data),
    .free_code (free_code)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] buf_word(input int b);
    return buf_data[b*DW +: DW];
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare all outputs against the reference rotation state
  task automatic check_all(input string tag);
    for (int j = 0; j < NT; j++) begin
      chk(tag, int'(tap_data[j*DW +: DW]), int'(buf_word((j + rot) % NB)));
    end
    chk(tag, int'(free_code), (NB - 1 + rot) % NB);
  endtask

  task automatic new_data();
    for (int b = 0; b < NB; b++) begin
      buf_data[b*DW +: DW] = DW'(($urandom % 32) * 8 + b);
    end
  endtask

  // One clock: drive, check routing before the edge, update model, check after
  task automatic cycle(input bit s, input bit i, input string tag);
    shift = s;
    init  = i;
    new_data();
    #1;
    check_all("R2 data routing before edge");
    @(posedge clk);
    if (i)      rot = 0;
    else if (s) rot = (rot + 1) % NB;
    @(negedge clk);
    check_all(tag);
  endtask

  // R8: five taps read five distinct buffers, none is the free one
  task automatic check_distinct();
    for (int b = 0; b < NB; b++) buf_data[b*DW +: DW] = DW'(8'h40 + b);
    #1;
    for (int j = 0; j < NT; j++) begin
      chk("R8 tap not free buffer", int'(tap_data[j*DW +: DW] == buf_word(int'(free_code))), 0);
      for (int k = j + 1; k < NT; k++) begin
        chk("R8 taps distinct", int'(tap_data[j*DW +: DW] == tap_data[k*DW +: DW]), 0);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    n_checks = 0; n_fail = 0; rot = 0; done = 0;
    rst_n = 1'b0; init = 1'b0; shift = 1'b0;
    new_data();
    #(CLK_PERIOD * 2 + 3);
    check_all("R1 reset arrangement");
    @(negedge clk);
    rst_n = 1'b1;
    // R5: idle cycles
    for (int c = 0; c < 3; c++) cycle(1'b0, 1'b0, "R5 hold");
    check_all("R1 start kept before shift");
    // R3 R4: shifts through all states, R7 wrap
    for (int c = 0; c < NB; c++) begin
      cycle(1'b1, 1'b0, "R3 R4 shift");
      check_distinct();
    end
    chk("R7 wrap free code", int'(free_code), NB - 1);
    chk("R7 wrap tap0", int'(tap_data[0 +: DW]), int'(buf_word(0)));
    // Mixed pattern with holds between shifts
    cycle(1'b1, 1'b0, "R4 shift");
    cycle(1'b0, 1'b0, "R5 hold after shift");
    cycle(1'b1, 1'b0, "R3 shift");
    cycle(1'b1, 1'b0, "R3 shift");
    cycle(1'b0, 1'b0, "R5 hold");
    // R6: init alone, then init with shift
    cycle(1'b0, 1'b1, "R6 init");
    cycle(1'b1, 1'b0, "R3 shift after init");
    cycle(1'b1, 1'b0, "R3 shift");
    cycle(1'b1, 1'b1, "R6 init wins over shift");
    chk("R6 free after init+shift", int'(free_code), NB - 1);
    // Long run, wraps several times
    for (int c = 0; c < 20; c++) cycle(1'b1, 1'b0, "R7 long rotation");
    check_distinct();
    // R1: asynchronous reset in mid-rotation
    cycle(1'b1, 1'b0, "R3 shift");
    #2;
    rst_n = 1'b0;
    rot = 0;
    #1;
    check_all("R1 async reset mid-rotation");
    @(negedge clk);
    rst_n = 1'b1;
    cycle(1'b0, 1'b0, "R1 after reset hold");
    cycle(1'b1, 1'b0, "R4 shift after reset");
    shift = 1'b0;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule